// File: doc/BRIEF.md
# Scheduled 3x3 Determinant Unit

This block computes the determinant of a 3x3 matrix of signed integers. It expands along the top row. Three two-input multipliers and three two-input adder/subtractors work in parallel under a fixed six-step schedule:

- Step 0 forms the first product of each 2x2 minor.
- Step 1 forms the second product of each minor.
- Step 2 takes the three minor differences.
- Step 3 scales each difference by its top-row element.
- Steps 4 and 5 combine the three scaled terms.

The middle term is subtracted.

A caller presents all nine elements at once on a packed input bus and raises `start` for one clock. The block captures the matrix and holds `busy` high while the schedule runs. It then pulses `done` for one cycle and presents the result on `det`. The result stays on `det` until the next computation completes. The result is wide enough that no input combination can overflow it.

Top module: `det3_sched`

## Requirements
- R1: With the element at row r, column c (r, c in 0..2) taken from `m_in[(3r+c)*W +: W]` as W-bit two's complement, and named a..i in row-major order, `det` equals a(ei−fh) − b(di−fg) + c(dh−eg) as a 3W+2-bit two's-complement value.
- R2: `done` is high for exactly one cycle, in the cycle that follows the sixth rising edge after the edge that accepted `start`.
- R3: `busy` is high from the edge that accepts `start` until the edge that raises `done`, and is low while `done` is high.
- R4: `start` has no effect while `busy` is high: the result and the timing of the running computation are unchanged. Holding `start` high restarts the unit on the first edge where `busy` is low.
- R5: `det` changes only at the edge that raises `done`, and otherwise holds its value.
- R6: A synchronous active-high `rst` clears `busy`, `done` and `det` to zero and abandons any computation in progress.
- R7: Inputs at the ends of the signed range (−2^(W−1) and 2^(W−1)−1) give the exact determinant without overflow. A singular matrix gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a computation when the unit is idle |
| m_in | input | 9*W | Matrix elements in row-major order, element k at bits k*W +: W |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when a result is ready |
| det | output | 3*W+2 | Signed determinant |

## Verification
Each accepted `start` is due to produce its `done` pulse and new `det` value six rising edges later. Until that edge, `busy` must be high, and `det` must keep its earlier value.

The bench's behavioural model records the acceptance edge and the expected value. It predicts `busy`, `done` and `det` for every cycle. All three outputs are compared at each falling edge. A one-cycle slip in the schedule, or a `start` wrongly taken while busy, therefore shows up as a mismatch in the cycle where it occurs.

// File: rtl/det3_sched.sv
module det3_sched #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [9*W-1:0] m_in,
  output logic           busy,
  output logic           done,
  output logic [3*W+1:0] det
);
  localparam int PW = 2*W;
  localparam int DW = 2*W+1;
  localparam int SW = 3*W+1;
  localparam int RW = 3*W+2;

  logic [9*W-1:0] mreg;
  logic [2:0]     step;

  logic signed [W-1:0]  el [9];
  logic signed [PW-1:0] p [3];
  logic signed [PW-1:0] q [3];
  logic signed [DW-1:0] d [3];
  logic signed [SW-1:0] s [3];
  logic signed [RW-1:0] acc;

  logic signed [DW-1:0] mx [3];
  logic signed [W-1:0]  my [3];
  logic signed [SW-1:0] mp [3];
  logic signed [RW-1:0] ax [3];
  logic signed [RW-1:0] ay [3];
  logic signed [RW-1:0] as [3];
  logic                 sub [3];

  for (genvar k = 0; k < 9; k++) begin : g_el
    assign el[k] = mreg[k*W +: W];
  end

  for (genvar u = 0; u < 3; u++) begin : g_unit
    assign mp[u] = mx[u] * my[u];
    assign as[u] = sub[u] ? ax[u] - ay[u] : ax[u] + ay[u];
  end

  always_comb begin
    for (int u = 0; u < 3; u++) begin
      mx[u] = '0;
      my[u] = '0;
    end
    case (step)
      3'd0: begin
        mx[0] = DW'(el[4]); my[0] = el[8];
        mx[1] = DW'(el[3]); my[1] = el[8];
        mx[2] = DW'(el[3]); my[2] = el[7];
      end
      3'd1: begin
        mx[0] = DW'(el[7]); my[0] = el[5];
        mx[1] = DW'(el[6]); my[1] = el[5];
        mx[2] = DW'(el[6]); my[2] = el[4];
      end
      3'd3: begin
        mx[0] = d[0]; my[0] = el[0];
        mx[1] = d[1]; my[1] = el[1];
        mx[2] = d[2]; my[2] = el[2];
      end
      default: ;
    endcase
  end

  always_comb begin
    for (int u = 0; u < 3; u++) begin
      ax[u]  = '0;
      ay[u]  = '0;
      sub[u] = 1'b0;
    end
    case (step)
      3'd2: begin
        for (int u = 0; u < 3; u++) begin
          ax[u]  = RW'(p[u]);
          ay[u]  = RW'(q[u]);
          sub[u] = 1'b1;
        end
      end
      3'd4: begin
        ax[0] = RW'(s[0]); ay[0] = RW'(s[1]); sub[0] = 1'b1;
      end
      3'd5: begin
        ax[1] = acc; ay[1] = RW'(s[2]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      step <= '0;
      det  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          mreg <= m_in;
          busy <= 1'b1;
          step <= '0;
        end
      end else begin
        step <= step + 3'd1;
        case (step)
          3'd0: for (int u = 0; u < 3; u++) p[u] <= PW'(mp[u]);
          3'd1: for (int u = 0; u < 3; u++) q[u] <= PW'(mp[u]);
          3'd2: for (int u = 0; u < 3; u++) d[u] <= DW'(as[u]);
          3'd3: for (int u = 0; u < 3; u++) s[u] <= mp[u];
          3'd4: acc <= as[0];
          default: begin
            det  <= as[1];
            done <= 1'b1;
            busy <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/det3_sched_chk.sv
module det3_sched_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [3*W+1:0] det
);
  logic [3:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (start && !busy) cnt <= 4'd1;
    else if (cnt != 4'd0 && cnt != 4'd15) cnt <= cnt + 4'd1;
  end

  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> cnt == 4'd7);
  a_r3_busy_low_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  a_r5_det_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(det));
  a_r6_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done));
endmodule

bind det3_sched det3_sched_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .det(det)
);

// File: tb/det3_sched_tb_top.sv
`timescale 1ns/1ps
module det3_sched_tb_top;
  localparam int W = 8;
  localparam int RW = 3*W+2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [9*W-1:0] m_in = '0;
  logic           busy;
  logic           done;
  logic [RW-1:0]  det;

  det3_sched #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .m_in(m_in),
    .busy(busy), .done(done), .det(det)
  );

  always #2.5 clk = ~clk;

  int     n_cmp = 0;
  int     n_bad = 0;
  int     cyc = 0;
  string  cur_tag = "R1";

  bit     m_busy = 0, m_done = 0, pend = 0;
  int     due = 0;
  longint m_det = 0, exp_det = 0;

  function automatic longint ref_det(input logic [9*W-1:0] m);
    longint e [9];
    for (int k = 0; k < 9; k++) e[k] = longint'($signed(m[k*W +: W]));
    return e[0]*(e[4]*e[8] - e[5]*e[7])
         - e[1]*(e[3]*e[8] - e[5]*e[6])
         + e[2]*(e[3]*e[7] - e[4]*e[6]);
  endfunction

  function automatic logic [9*W-1:0] pack9(input int v [9]);
    logic [9*W-1:0] r;
    for (int k = 0; k < 9; k++) r[k*W +: W] = W'(v[k]);
    return r;
  endfunction

  always @(posedge clk) begin
    bit acc;
    cyc++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_det = 0; pend = 0;
    end else begin
      acc = start && !m_busy;
      m_done = 0;
      if (pend && cyc == due) begin
        m_done = 1; m_det = exp_det; pend = 0; m_busy = 0;
      end
      if (acc) begin
        pend = 1; due = cyc + 6; exp_det = ref_det(m_in); m_busy = 1;
      end
    end
  end

  always @(negedge clk) begin
    string tg;
    longint got;
    tg = rst ? "R6" : "R3";
    n_cmp++;
    if (busy !== m_busy) begin
      n_bad++;
      $display("FAIL %s busy cyc %0d: got %0b exp %0b", tg, cyc, busy, m_busy);
    end
    tg = rst ? "R6" : "R2";
    n_cmp++;
    if (done !== m_done) begin
      n_bad++;
      $display("FAIL %s done cyc %0d: got %0b exp %0b", tg, cyc, done, m_done);
    end
    tg = rst ? "R6" : (m_done ? cur_tag : "R5");
    got = longint'($signed(det));
    n_cmp++;
    if (got !== m_det) begin
      n_bad++;
      $display("FAIL %s det cyc %0d: got %0d exp %0d", tg, cyc, got, m_det);
    end
  end

  task automatic run_one(input logic [9*W-1:0] m, input string tag);
    @(negedge clk);
    cur_tag = tag;
    m_in = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  initial begin
    int mx;
    int mn;
    mx = (1 << (W-1)) - 1;
    mn = -(1 << (W-1));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    run_one(pack9('{1,0,0, 0,1,0, 0,0,1}), "R1");
    run_one(pack9('{2,-3,1, 4,0,-5, -1,6,7}), "R1");
    run_one(pack9('{0,1,0, 1,0,0, 0,0,1}), "R1");
    run_one(pack9('{1,2,3, 4,5,6, 7,8,9}), "R7");
    run_one(pack9('{3,-1,4, 3,-1,4, 5,9,2}), "R7");
    run_one(pack9('{mn,0,0, 0,mn,0, 0,0,mn}), "R7");
    run_one(pack9('{mx,0,0, 0,mx,0, 0,0,mx}), "R7");
    run_one(pack9('{mn,mx,mn, mx,mn,mx, mn,mx,mx}), "R7");
    run_one(pack9('{mn,mn,mn, mn,mn,mn, mn,mn,mn}), "R7");
    run_one(pack9('{mn,mx,mx, mx,mn,mx, mx,mx,mn}), "R7");

    for (int t = 0; t < 40; t++) begin
      logic [9*W-1:0] r;
      for (int k = 0; k < 9; k++) r[k*W +: W] = W'($urandom);
      run_one(r, "R1");
    end

    @(negedge clk);
    cur_tag = "R4";
    m_in = pack9('{5,1,-2, 3,7,4, -6,2,1});
    start = 1'b1;
    @(negedge clk);
    m_in = pack9('{9,9,9, 1,2,3, 4,4,4});
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);

    for (int t = 0; t < 3; t++) begin
      m_in = pack9('{t+1,2,-t, 4,t-3,6, 7,-8,t});
      start = 1'b1;
      repeat (7) @(negedge clk);
    end
    start = 1'b0;
    repeat (8) @(negedge clk);

    cur_tag = "R6";
    m_in = pack9('{1,2,3, 0,1,4, 5,6,0});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (8) @(negedge clk);

    run_one(pack9('{1,2,3, 0,1,4, 5,6,0}), "R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule